// File: doc/BRIEF.md
# Single-Error-Correcting Asynchronous Serial Receiver

This block takes an asynchronous serial line and recovers data words of 8, 16 or 32 bits. The line idles high. Each frame begins with a low start bit and ends with a high stop bit. Between them the line carries either a Hamming code word or the data bits followed by one even-parity bit. The bit period is set by a 16-bit divisor. A falling edge on the line is confirmed half a period later. From then on, every bit is sampled at the centre of its period.

In Hamming mode the block recomputes the check bits from the received code word and compares them with the check bits that were received. The result is a syndrome. A nonzero syndrome that lies inside the code word names one bit, and the block inverts that bit. The decode runs as a pipeline stage behind the sampler, so the next frame can be shifted in while the previous one is corrected. Each result is delivered as a one-clock valid pulse together with flags. The flags report a corrected word, an error that was detected but not corrected, or a framing error.

Top module: `hrx_top`

## Requirements
- R1: While reset is held, and after it is released, rx_valid, rx_fixed, rx_chk_err and rx_frm_err are 0 and rx_word is 0.
- R2: One bit period is baud_div+1 clocks. A low level is taken as a start bit only if it is still low (baud_div>>1) clocks after the falling edge. A pulse shorter than that produces no output.
- R3: In Hamming mode (ham_en=1), code positions 1, 2, 4, 8, 16 and 32 carry check bits. All other positions carry data bits, lowest data bit at the lowest position. Code position 1 is the first bit after the start bit. Check bit 2^i is the even parity of the data positions whose index has bit i set. The code lengths are 12, 21 and 38 bits, so frames are 14, 23 and 40 bits long.
- R4: A Hamming frame with a zero syndrome is delivered with rx_fixed=0 and rx_chk_err=0.
- R5: A Hamming frame whose syndrome s satisfies 1 <= s <= code length has the bit at position s inverted. The true data is delivered with rx_fixed=1.
- R6: A Hamming frame whose syndrome exceeds the code length is delivered uncorrected, with rx_chk_err=1 and rx_fixed=0.
- R7: In parity mode (ham_en=0) a frame carries the data LSB first, then one even-parity bit. A parity mismatch sets rx_chk_err=1 with the data as received. rx_fixed stays 0.
- R8: A stop bit sampled as 0 pulses rx_frm_err for one clock instead of rx_valid. The receiver then waits for a new falling edge.
- R9: Suppose the line is first seen low at clock edge 0 and the frame has L bits with divisor D. Then the result is on the outputs after edge 4+(D>>1)+(L-1)(D+1), for exactly one clock.
- R10: A frame whose start bit follows the previous stop bit with no idle gap is received correctly.
- R11: wsel selects the data width (0: 8 bits, 1: 16 bits, 2: 32 bits). Bits of rx_word above the selected width are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| wsel | input | 2 | Data width select |
| ham_en | input | 1 | 1: Hamming code word, 0: single parity bit |
| baud_div | input | 16 | Bit period minus one, in clocks |
| rx_word | output | 32 | Last delivered data word |
| rx_valid | output | 1 | One-clock pulse when a word is delivered |
| rx_fixed | output | 1 | A single bit was corrected in this word |
| rx_chk_err | output | 1 | Check error detected, not corrected |
| rx_frm_err | output | 1 | Stop bit was low |

## Verification
A wrong baud count or a misplaced half-bit check changes the cycle in which rx_valid pulses. The bench predicts that cycle exactly and compares every clock, so such a fault appears at the end of the first frame. A syndrome or bit-extraction fault shows up as a wrong word or wrong flags in the first frame that uses the affected position. For that reason every code position of the byte format is flipped in turn, along with the end positions of the wider formats. A sampler that fails to return to idle, or that accepts glitches, produces spurious or missing pulses, and the per-clock comparison catches them within one frame.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    localparam int DIV_W  = 16;
    localparam int DW_MAX = 32;
    localparam int CW_MAX = 38;
    localparam int SYN_W  = 6;
    localparam int IDX_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS
    } rx_st_e;

    typedef struct packed {
        logic              vld;
        logic              stop_ok;
        logic              ham;
        logic [1:0]        wsel;
        logic [CW_MAX-1:0] cw;
    } frame_t;

    function automatic logic [IDX_W-1:0] dbits(input logic [1:0] ws);
        case (ws)
            2'b00:   return 6'd8;
            2'b01:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] cbits(input logic ham, input logic [1:0] ws);
        if (ham) begin
            case (ws)
                2'b00:   return 6'd12;
                2'b01:   return 6'd21;
                default: return 6'd38;
            endcase
        end
        return dbits(ws) + 6'd1;
    endfunction

endpackage

// File: rtl/hrx_sampler.sv
module hrx_sampler
    import hrx_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          ham_i,
    input  logic [1:0]    wsel_i,
    input  logic [DW-1:0] div_i,
    output frame_t        frame_o
);

    typedef struct packed {
        rx_st_e            st;
        logic [DW-1:0]     cnt;
        logic [IDX_W-1:0]  idx;
        logic [2:0]        sync;
        logic              ham;
        logic [1:0]        wsel;
        logic [CW_MAX-1:0] cw;
        frame_t            fr;
    } smp_t;

    smp_t q, d;
    logic          line;
    logic          fall;
    logic [DW-1:0] half;
    logic [IDX_W-1:0] nbits;

    assign line  = q.sync[1];
    assign fall  = q.sync[2] & ~q.sync[1];
    assign half  = div_i >> 1;
    assign nbits = cbits(q.ham, q.wsel);

    always_comb begin
        d        = q;
        d.sync   = {q.sync[1:0], rxd};
        d.fr.vld = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (fall) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (q.cnt >= half) begin
                    d.cnt = '0;
                    if (!line) begin
                        d.st   = ST_BITS;
                        d.idx  = '0;
                        d.ham  = ham_i;
                        d.wsel = wsel_i;
                        d.cw   = '0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_BITS: begin
                if (q.cnt >= div_i) begin
                    d.cnt = '0;
                    if (q.idx == nbits) begin
                        d.st         = ST_IDLE;
                        d.fr.vld     = 1'b1;
                        d.fr.stop_ok = line;
                        d.fr.ham     = q.ham;
                        d.fr.wsel    = q.wsel;
                        d.fr.cw      = q.cw;
                    end else begin
                        d.cw[q.idx] = line;
                        d.idx       = q.idx + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.sync <= 3'b111;
        end else begin
            q <= d;
        end
    end

    assign frame_o = q.fr;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !fall) |=> q.st == ST_IDLE);

    // R8
    handoff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fr.vld |-> q.st == ST_IDLE);

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BITS) |-> q.idx <= nbits);

endmodule

// File: rtl/hrx_decode.sv
module hrx_decode
    import hrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  frame_t            fr_i,
    output logic [DW_MAX-1:0] word_o,
    output logic              valid_o,
    output logic              fixed_o,
    output logic              chk_o,
    output logic              frm_o
);

    typedef struct packed {
        logic [DW_MAX-1:0] word;
        logic              valid;
        logic              fixed;
        logic              chk;
        logic              frm;
    } out_t;

    out_t q, d;

    logic [IDX_W-1:0] ncode;
    logic [SYN_W-1:0] regen;
    logic [SYN_W-1:0] recv;
    logic [SYN_W-1:0] syn;

    assign ncode = cbits(fr_i.ham, fr_i.wsel);

    function automatic logic regen_bit(input logic [CW_MAX-1:0] cw, input int n, input int b);
        logic x;
        x = 1'b0;
        for (int p = 1; p <= CW_MAX; p++) begin
            if (p <= n && (p & (p - 1)) != 0 && ((p >> b) & 1) == 1) x ^= cw[p-1];
        end
        return x;
    endfunction

    for (genvar i = 0; i < SYN_W; i++) begin : g_chk
        assign regen[i] = regen_bit(fr_i.cw, int'(ncode), i);
        assign recv[i]  = ((1 << i) <= int'(ncode)) ? fr_i.cw[(1<<i)-1] : 1'b0;
    end

    assign syn = regen ^ recv;

    always_comb begin
        logic [CW_MAX-1:0] fcw;
        logic [DW_MAX-1:0] dat;
        logic              par;
        logic              fix;
        logic              bad;
        int                n;
        int                w;
        int                k;
        n   = int'(ncode);
        w   = int'(dbits(fr_i.wsel));
        fcw = fr_i.cw;
        dat = '0;
        par = 1'b0;
        fix = 1'b0;
        bad = 1'b0;
        k   = 0;
        if (fr_i.ham) begin
            if (syn != '0) begin
                if (int'(syn) <= n) begin
                    fcw[int'(syn) - 1] = ~fcw[int'(syn) - 1];
                    fix = 1'b1;
                end else begin
                    bad = 1'b1;
                end
            end
            for (int p = 1; p <= CW_MAX; p++) begin
                if (p <= n && (p & (p - 1)) != 0) begin
                    if (k < DW_MAX) dat[k] = fcw[p-1];
                    k++;
                end
            end
        end else begin
            for (int i = 0; i < CW_MAX; i++) begin
                if (i < w) dat[i] = fr_i.cw[i];
                if (i <= w) par ^= fr_i.cw[i];
            end
            bad = par;
        end
        d       = q;
        d.valid = fr_i.vld & fr_i.stop_ok;
        d.frm   = fr_i.vld & ~fr_i.stop_ok;
        d.fixed = d.valid & fix;
        d.chk   = d.valid & bad;
        if (d.valid) d.word = dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o  = q.word;
    assign valid_o = q.valid;
    assign fixed_o = q.fixed;
    assign chk_o   = q.chk;
    assign frm_o   = q.frm;

    // R5
    fixed_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fixed |-> (q.valid && !q.chk));

    // R8
    frm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.valid && q.frm));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R7
    parity_nofix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_i.vld && !fr_i.ham) |=> !q.fixed);

    // R11
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_i.vld && fr_i.stop_ok && fr_i.wsel == 2'b00) |=> q.word[DW_MAX-1:8] == '0);

endmodule

// File: rtl/hrx_top.sv
module hrx_top
    import hrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [1:0]        wsel,
    input  logic              ham_en,
    input  logic [DIV_W-1:0]  baud_div,
    output logic [DW_MAX-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_fixed,
    output logic              rx_chk_err,
    output logic              rx_frm_err
);

    frame_t frame;

    hrx_sampler #(.DW(DIV_W)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .ham_i   (ham_en),
        .wsel_i  (wsel),
        .div_i   (baud_div),
        .frame_o (frame)
    );

    hrx_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .fr_i    (frame),
        .word_o  (rx_word),
        .valid_o (rx_valid),
        .fixed_o (rx_fixed),
        .chk_o   (rx_chk_err),
        .frm_o   (rx_frm_err)
    );

endmodule

// File: tb/tb_hrx_top.sv
module tb_hrx_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rxd;
    logic [1:0]  wsel;
    logic        ham_en;
    logic [15:0] baud_div;
    logic [31:0] rx_word;
    logic        rx_valid, rx_fixed, rx_chk_err, rx_frm_err;

    hrx_top dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .wsel(wsel), .ham_en(ham_en),
        .baud_div(baud_div), .rx_word(rx_word), .rx_valid(rx_valid),
        .rx_fixed(rx_fixed), .rx_chk_err(rx_chk_err), .rx_frm_err(rx_frm_err)
    );

    always #4 clk = ~clk;

    typedef struct {
        int          due;
        logic [31:0] w;
        bit          v;
        bit          f;
        bit          c;
        bit          fe;
        string       tag;
    } exp_t;

    exp_t  eq[$];
    int    ecnt  = 0;
    int    total = 0;
    int    bad   = 0;
    bit    mon_on = 0;
    bit    done   = 0;
    string cur_tag = "R9";

    always @(posedge clk) ecnt++;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (eq.size() > 0 && eq[0].due == ecnt) begin
                chk(eq[0].tag, "valid", {31'd0, rx_valid},   {31'd0, eq[0].v});
                chk(eq[0].tag, "fixed", {31'd0, rx_fixed},   {31'd0, eq[0].f});
                chk(eq[0].tag, "chk",   {31'd0, rx_chk_err}, {31'd0, eq[0].c});
                chk(eq[0].tag, "frm",   {31'd0, rx_frm_err}, {31'd0, eq[0].fe});
                if (eq[0].v) chk(eq[0].tag, "word", rx_word, eq[0].w);
                void'(eq.pop_front());
            end else begin
                chk(cur_tag, "idle pulses", {28'd0, rx_valid, rx_fixed, rx_chk_err, rx_frm_err}, 32'd0);
            end
        end
    end

    function automatic int hlen(input int w);
        return (w == 8) ? 12 : ((w == 16) ? 21 : 38);
    endfunction

    // Send one frame; f1/f2 are code positions to flip (0 = none).
    task automatic send(input bit ham, input int w, input logic [31:0] val,
                        input int f1, input int f2, input bit stopb, input int gap,
                        input string tag);
        bit   c [0:40];
        int   n, d, s, L, D, ub;
        exp_t e;
        logic [31:0] ew;
        D = int'(baud_div);
        for (int i = 0; i <= 40; i++) c[i] = 1'b0;
        e.f = 0; e.c = 0; ew = '0;
        ham_en = ham;
        wsel   = (w == 8) ? 2'd0 : ((w == 16) ? 2'd1 : 2'd2);
        if (ham) begin
            n = hlen(w);
            d = 0;
            for (int p = 1; p <= n; p++) if ((p & (p - 1)) != 0) begin c[p] = val[d]; d++; end
            for (int i = 0; (1 << i) <= n; i++) begin
                bit x;
                x = 0;
                for (int p = 1; p <= n; p++) if (p != (1 << i) && (p & (1 << i)) != 0) x ^= c[p];
                c[1 << i] = x;
            end
        end else begin
            n = w + 1;
            for (int i = 0; i < w; i++) c[i+1] = val[i];
            c[w+1] = ^(val & ((w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1)));
        end
        if (f1 > 0) c[f1] = ~c[f1];
        if (f2 > 0) c[f2] = ~c[f2];
        if (ham) begin
            bit cc [0:40];
            cc = c;
            s = 0;
            for (int p = 1; p <= n; p++) if (c[p]) s ^= p;
            if (s >= 1 && s <= n) begin cc[s] = ~cc[s]; e.f = 1; end
            else if (s > n) e.c = 1;
            d = 0;
            for (int p = 1; p <= n; p++) if ((p & (p - 1)) != 0) begin ew[d] = cc[p]; d++; end
        end else begin
            ub = 0;
            for (int i = 1; i <= n; i++) ub ^= int'(c[i]);
            e.c = (ub != 0);
            for (int i = 0; i < w; i++) ew[i] = c[i+1];
        end
        L     = n + 2;
        e.due = ecnt + 1 + 4 + (D >> 1) + (L - 1) * (D + 1);
        e.v   = stopb;
        e.fe  = !stopb;
        if (!stopb) begin e.f = 0; e.c = 0; end
        e.w   = ew;
        e.tag = tag;
        eq.push_back(e);
        rxd = 1'b0;
        repeat (D + 1) @(negedge clk);
        for (int i = 1; i <= n; i++) begin
            rxd = c[i];
            repeat (D + 1) @(negedge clk);
        end
        rxd = stopb;
        repeat (D + 1) @(negedge clk);
        rxd = 1'b1;
        repeat (gap * (D + 1)) @(negedge clk);
    endtask

    initial begin
        rxd = 1'b1; ham_en = 1'b1; wsel = 2'd0; baud_div = 16'd7; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "flags in reset", {28'd0, rx_valid, rx_fixed, rx_chk_err, rx_frm_err}, 32'd0);
        chk("R1", "word in reset", rx_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "word after reset", rx_word, 32'd0);
        mon_on = 1;
        repeat (4) @(negedge clk);

        // R4 / R3: clean byte frames
        send(1, 8, 32'hA5, 0, 0, 1, 1, "R4");
        send(1, 8, 32'h00, 0, 0, 1, 1, "R3");
        // R5: every code position of the byte format
        for (int p = 1; p <= 12; p++) send(1, 8, 32'h5A ^ p, p, 0, 1, 1, "R5");
        // R6: syndrome 13 exceeds 12
        send(1, 8, 32'hC3, 5, 8, 1, 1, "R6");
        // R11 / R3: 16-bit
        send(1, 16, 32'hBEEF, 0, 0, 1, 1, "R11");
        send(1, 16, 32'h1234, 21, 0, 1, 1, "R5");
        send(1, 16, 32'h8001, 10, 21, 1, 1, "R6");
        // R11 / R3: 32-bit
        send(1, 32, 32'hDEADBEEF, 0, 0, 1, 1, "R11");
        send(1, 32, 32'h0F0F1234, 38, 0, 1, 1, "R5");
        send(1, 32, 32'h80000001, 32, 0, 1, 1, "R5");
        send(1, 32, 32'h13579BDF, 33, 30, 1, 1, "R6");
        // R7: parity mode
        send(0, 8, 32'h3C, 0, 0, 1, 1, "R7");
        send(0, 8, 32'h3C, 3, 0, 1, 1, "R7");
        send(0, 16, 32'hA0A1, 0, 0, 1, 1, "R7");
        send(0, 32, 32'hCAFEF00D, 33, 0, 1, 1, "R7");
        // R8: framing error then recovery
        send(1, 8, 32'h77, 0, 0, 0, 2, "R8");
        send(1, 8, 32'h78, 0, 0, 1, 1, "R8");
        // R2: short glitch rejected
        cur_tag = "R2";
        rxd = 1'b0;
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * 8) @(negedge clk);
        cur_tag = "R9";
        send(1, 8, 32'h96, 0, 0, 1, 1, "R2");
        // R10: back-to-back frames with pending correction
        send(1, 32, 32'h01234567, 7, 0, 1, 0, "R10");
        send(1, 32, 32'h89ABCDEF, 0, 0, 1, 0, "R10");
        send(1, 16, 32'h4321, 3, 0, 1, 1, "R10");
        // R2: other divisors
        baud_div = 16'd4;
        send(1, 32, 32'h55AA33CC, 12, 0, 1, 1, "R2");
        baud_div = 16'd12;
        send(0, 16, 32'h7E81, 0, 0, 1, 1, "R2");
        send(1, 8, 32'hE1, 0, 0, 1, 1, "R2");
        repeat (30) @(negedge clk);
        chk("R9", "pending results", eq.size(), 32'd0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule